// File: doc/BRIEF.md
# Configurable Edge-Triggered Event Controller

The block watches a vector of external event lines and turns selected transitions into latched pending flags and one interrupt request. Only a sparse subset of the line positions is configurable: lines 0 to 16, 21 and 22. All other positions are reserved. For each configurable line, software chooses whether a rising edge, a falling edge, or both raise an event. Inputs pass through a two-flop synchronizer before edge detection.

Software can also fire an event on any configurable line by writing a one to that line's bit in a self-clearing trigger register. This bypasses the edge enables. Pending flags are cleared by writing ones, and a mask register selects which pending flags drive the interrupt output. Access is through a single-cycle register bus: writes take effect at the clock edge, and reads are combinational from the address.

Top module: `evt_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: Only bit positions 0 to 16, 21 and 22 are implemented in every register. The other positions read 0 and ignore writes, and transitions on those input lines never set a pending bit.
- R3: With a line's rising enable set (offset 0x00), a 0-to-1 change on its input sets its pending bit on the third rising clock edge after the change. The bit is not set after the second. A falling change does not set it.
- R4: With a line's falling enable set (offset 0x04), a 1-to-0 change on its input sets its pending bit.
- R5: With both enables set for a line, each transition in either direction sets its pending bit.
- R6: With neither enable set, transitions on a line do not set its pending bit.
- R7: Writing 1 to a bit of the trigger register (offset 0x08) sets that line's pending bit on the same clock edge, whatever the edge enables are. Writing 0 has no effect.
- R8: The trigger register always reads back as 0.
- R9: Writing 1 to a pending bit (offset 0x0C) clears it. Writing 0 leaves it unchanged.
- R10: If an event arrives on a line in the same cycle that its pending bit is being cleared, the bit stays set.
- R11: `irq_o` is 1 exactly when some pending bit has its mask bit (offset 0x10) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte offset |
| we_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| evt_i | input | 32 | Asynchronous event lines |
| irq_o | output | 1 | Masked OR of the pending flags |

## Verification
A wrong edge history or synchronizer stage shows up in the pending register and `irq_o` three edges after an input change, as a missing event, an early event or an event in the wrong direction. A stuck or wrongly merged pending bit shows up at once on a read of offset 0x0C, and through `irq_o` when that line is unmasked. A wrong trigger-register state shows up either as a nonzero read of offset 0x08 or as pending bits that were never requested. Leakage onto reserved positions shows up in the first read after a write of all ones.

// File: rtl/evt_ctrl_pkg.sv
package evt_ctrl_pkg;
  localparam int unsigned ADDR_W = 5;
  typedef enum logic [ADDR_W-1:0] {
    OFF_RISE = 5'h00,
    OFF_FALL = 5'h04,
    OFF_SWT  = 5'h08,
    OFF_PEND = 5'h0C,
    OFF_MASK = 5'h10
  } reg_off_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    assign ev_o[i] = (rise_en_i[i] &  lvl_i[i] & ~prev_q[i])
                   | (fall_en_i[i] & ~lvl_i[i] &  prev_q[i]);
  end

  // R6
  only_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o & ~(lvl_i ^ $past(lvl_i))) == '0);
  // R3
  rise_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o & lvl_i & ~rise_en_i) == '0);
  // R4
  fall_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o & ~lvl_i & ~fall_en_i) == '0);
endmodule

// File: rtl/evt_pending.sv
module evt_pending #(
  parameter int unsigned   W    = 32,
  parameter logic [W-1:0]  IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= ((pend_q & ~clr_i) | set_i) & IMPL;
  end
  assign pend_o = pend_q;

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(set_i & IMPL) |=> ((pend_q & $past(set_i & IMPL)) == $past(set_i & IMPL)));
  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(clr_i & ~set_i) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(pend_q));
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_ctrl_pkg::*;
#(
  parameter int unsigned         N_LINES = 32,
  parameter logic [N_LINES-1:0]  IMPL    = 32'h0061_FFFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [N_LINES-1:0] wdata_i,
  output logic [N_LINES-1:0] rdata_o,
  input  logic [N_LINES-1:0] evt_i,
  output logic               irq_o
);
  localparam int unsigned W = N_LINES;

  logic [W-1:0] rise_q, fall_q, mask_q;
  logic [W-1:0] lvl, hw_ev, sw_ev, clr, pend;
  logic [W-1:0] wmask;

  assign wmask = wdata_i & IMPL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFF_RISE: rise_q <= wmask;
        OFF_FALL: fall_q <= wmask;
        OFF_MASK: mask_q <= wmask;
        default: ;
      endcase
    end
  end

  assign sw_ev = (we_i && addr_i == OFF_SWT)  ? wmask : '0;
  assign clr   = (we_i && addr_i == OFF_PEND) ? wmask : '0;

  evt_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (evt_i),
    .q_o   (lvl)
  );

  evt_edge_det #(.W(W)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl),
    .rise_en_i(rise_q),
    .fall_en_i(fall_q),
    .ev_o     (hw_ev)
  );

  evt_pending #(.W(W), .IMPL(IMPL)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (hw_ev | sw_ev),
    .clr_i (clr),
    .pend_o(pend)
  );

  always_comb begin
    case (addr_i)
      OFF_RISE: rdata_o = rise_q;
      OFF_FALL: rdata_o = fall_q;
      OFF_PEND: rdata_o = pend;
      OFF_MASK: rdata_o = mask_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = |(pend & mask_q);

  // R7
  sw_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |sw_ev |=> ((pend & $past(sw_ev)) == $past(sw_ev)));
  // R2
  reserved_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend & ~IMPL) == '0);
  // R11
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> !irq_o);
endmodule

// File: tb/tb_evt_ctrl.sv
`timescale 1ns/1ps
module tb_evt_ctrl;
  import evt_ctrl_pkg::*;

  localparam logic [31:0] IMPL = 32'h0061_FFFF;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [31:0]       evt = '0;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_ctrl dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .addr_i (addr),
    .we_i   (we),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .evt_i  (evt),
    .irq_o  (irq)
  );

  // {rise, fall, level before, level after, expected pending}
  localparam logic [159:0] VEC [7] = '{
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001}, // R3
    {32'h0000_0000, 32'h0000_0002, 32'h0000_0002, 32'h0000_0000, 32'h0000_0002}, // R4
    {32'h0000_000C, 32'h0000_000C, 32'h0000_0008, 32'h0000_0004, 32'h0000_000C}, // R5
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000}, // R6
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0061_FFFF}, // R2
    {32'h0001_0000, 32'h0060_0000, 32'h0060_0000, 32'h0001_0000, 32'h0061_0000}, // R4
    {32'h0000_0020, 32'h0000_0000, 32'h0000_0020, 32'h0000_0000, 32'h0000_0000}  // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(OFF_RISE, v); chk("R1 rise", v, '0);
    rd(OFF_FALL, v); chk("R1 fall", v, '0);
    rd(OFF_SWT,  v); chk("R1 swt", v, '0);
    rd(OFF_PEND, v); chk("R1 pend", v, '0);
    rd(OFF_MASK, v); chk("R1 mask", v, '0);
    chk("R1 irq", {31'b0, irq}, '0);

    // R2 reserved positions
    wr(OFF_RISE, 32'hFFFF_FFFF); rd(OFF_RISE, v); chk("R2 rise", v, IMPL);
    wr(OFF_MASK, 32'hFFFF_FFFF); rd(OFF_MASK, v); chk("R2 mask", v, IMPL);
    wr(OFF_RISE, '0); wr(OFF_MASK, '0);

    // table walk
    foreach (VEC[i]) begin
      wr(OFF_RISE, '0); wr(OFF_FALL, '0);
      evt = VEC[i][95:64];
      repeat (4) @(negedge clk);
      wr(OFF_RISE, VEC[i][159:128]);
      wr(OFF_FALL, VEC[i][127:96]);
      wr(OFF_PEND, 32'hFFFF_FFFF);
      evt = VEC[i][63:32];
      repeat (4) @(negedge clk);
      rd(OFF_PEND, v);
      chk($sformatf("R3/R4/R5/R6/R2 vector %0d", i), v, VEC[i][31:0]);
    end

    // R3 latency, observed on irq
    wr(OFF_FALL, '0); wr(OFF_RISE, 32'h1); wr(OFF_MASK, 32'h1);
    evt = '0;
    repeat (4) @(negedge clk);
    wr(OFF_PEND, 32'hFFFF_FFFF);
    evt = 32'h1;
    @(negedge clk); @(negedge clk);
    chk("R3 latency 2 edges", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R3 latency 3 edges", {31'b0, irq}, 32'h1);

    // R10 clear in the same cycle as an event
    evt = '0;
    repeat (4) @(negedge clk);
    rd(OFF_PEND, v); chk("R10 precondition", v, 32'h1);
    evt = 32'h1;
    @(negedge clk); @(negedge clk);
    wr(OFF_PEND, 32'h1);
    rd(OFF_PEND, v); chk("R10 event beats clear", v, 32'h1);

    // R9 clear and write-zero
    wr(OFF_PEND, 32'h0);
    rd(OFF_PEND, v); chk("R9 write zero", v, 32'h1);
    wr(OFF_PEND, 32'h1);
    rd(OFF_PEND, v); chk("R9 write one clears", v, 32'h0);
    wr(OFF_RISE, '0); wr(OFF_MASK, '0);

    // R7 / R8 software trigger
    wr(OFF_SWT, 32'h0);
    rd(OFF_PEND, v); chk("R7 write zero", v, 32'h0);
    wr(OFF_SWT, 32'h0040_0022);
    rd(OFF_PEND, v); chk("R7 trigger ignores enables", v, 32'h0040_0022);
    rd(OFF_SWT, v);  chk("R8 reads zero", v, 32'h0);
    wr(OFF_SWT, 32'h0010_0000);
    rd(OFF_PEND, v); chk("R2 reserved trigger", v, 32'h0040_0022);

    // R11 mask gating
    chk("R11 all masked", {31'b0, irq}, 32'h0);
    wr(OFF_MASK, 32'h0000_0002);
    chk("R11 line 1 unmasked", {31'b0, irq}, 32'h1);
    wr(OFF_PEND, 32'h0000_0002);
    chk("R11 only masked pending left", {31'b0, irq}, 32'h0);
    wr(OFF_MASK, 32'h0040_0000);
    chk("R11 line 22 unmasked", {31'b0, irq}, 32'h1);

    finish_run();
  end
endmodule